// File: doc/BRIEF.md
# Receive Mailbox Bank with Overwrite Protection

This block sits behind a CAN receiver and holds every decoded frame in one of a set of receive mailboxes. A frame arrives as one valid cycle carrying the identifier, the extended-format flag, the remote flag, the length code and eight data bytes. The bank looks for a mailbox whose identifier filter accepts the frame, starting at the highest index and moving down. It copies the identifier, control, payload and a local time stamp into the first mailbox that is able to take the frame, and sets that mailbox's pending flag.

Each mailbox has an overwrite-protect bit. If a mailbox is protected and still pending, it is skipped, so a frame that matches several protected mailboxes fills them one after another. If a mailbox is unprotected and still pending, it is overwritten and its lost flag is set. A row of protected mailboxes that ends in one unprotected mailbox therefore behaves as a receive FIFO that reports overflow. When no mailbox can take a frame, the frame is dropped and a sticky drop flag is raised. Software reads the mailboxes and clears the flags through a simple word-wide register port.

Top module: `rx_mbox_bank`

## Requirements
- R1: Storing a frame in mailbox i sets pending bit i on the next clock edge. Writing a one to a bit of the pending register (global word 0) clears that bit. A store in the same cycle takes precedence over the clear.
- R2: Mailboxes are searched from the highest index downward. A frame goes to the highest-indexed mailbox that accepts it, and to only that mailbox.
- R3: A mailbox that is pending and has its protect bit set (global word 2, bit i) is never written. The frame passes on to the next lower mailbox that accepts it.
- R4: A mailbox that is pending and unprotected is overwritten by a matching frame, and its bit in the lost register (global word 1) sets. Writing a one clears a lost bit.
- R5: Mailbox identifier word (word 0): bit 31 is the extended flag, bit 30 enables masking, and bits 28:0 hold an extended identifier or a standard identifier shifted left by 18. On a store, the word takes the received identifier and flag and keeps bit 30. Control word (word 1): length code in bits 3:0 and the remote flag in bit 4.
- R6: With bit 30 clear, a mailbox accepts only frames whose extended flag and identifier bits equal those of its identifier word. With bit 30 set, each one bit in the mailbox's mask word (word 5) makes the same bit position a don't-care, so a mask of all ones accepts any frame.
- R7: A free-running time counter starts at zero after reset, advances by one every clock, and can be read at global word 4. A stored frame's stamp (mailbox word 4) is the counter value in the cycle the frame was presented.
- R8: Input byte k sits at frm_data[8k+7:8k]. Bytes 0 to 3 are stored in data word low (word 2), and bytes 4 to 7 in data word high (word 3), with the lower-numbered byte in the more significant position.
- R9: A frame that no mailbox can take changes no mailbox or flag. It sets bit 0 of the status register (global word 3) and rx_drop_irq. Writing a one to that bit clears it.
- R10: The address is {global, mailbox, word}. The top bit selects the global registers. Below it are the mailbox index bits and then a 3-bit word index.
- R11: After reset, the pending, lost, protect and status registers read zero, and every identifier and mask word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | One-cycle strobe for a decoded frame |
| frm_id | input | 29 | Identifier (standard frames use bits 10:0) |
| frm_ext | input | 1 | Extended-format frame |
| frm_rtr | input | 1 | Remote frame |
| frm_len | input | 4 | Length code |
| frm_data | input | 64 | Data bytes; byte k at bits 8k+7:8k |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address {global, mailbox, word} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| rx_pend | output | NUM_MBOX | Pending flags |
| rx_drop_irq | output | 1 | Sticky flag for a dropped frame |

## Verification
The bench builds the bank with four mailboxes and the full 32-bit stamp. With only four mailboxes, a short run of frames fills every mailbox, so the bench reaches protected pass-over, overwrite of the unprotected lowest mailbox and a full drop. The configuration uses one mailbox with exact matching and three that accept everything, so the descending search and the mask don't-care bits can each be seen in the pending vector.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;
  // per-mailbox word index
  localparam logic [2:0] WD_ID    = 3'd0;
  localparam logic [2:0] WD_CTL   = 3'd1;
  localparam logic [2:0] WD_DLO   = 3'd2;
  localparam logic [2:0] WD_DHI   = 3'd3;
  localparam logic [2:0] WD_STAMP = 3'd4;
  localparam logic [2:0] WD_MASK  = 3'd5;
  // global word index
  localparam logic [2:0] GW_PEND  = 3'd0;
  localparam logic [2:0] GW_LOST  = 3'd1;
  localparam logic [2:0] GW_PROT  = 3'd2;
  localparam logic [2:0] GW_STAT  = 3'd3;
  localparam logic [2:0] GW_TIME  = 3'd4;

  // identifier word bits that take part in matching (30, 29 excluded)
  localparam logic [31:0] ID_CARE = 32'h9FFF_FFFF;

  function automatic logic [31:0] id_word(input logic [28:0] id, input logic ext);
    id_word = ext ? {1'b1, 2'b00, id} : {1'b0, 2'b00, id[10:0], 18'd0};
  endfunction

  function automatic logic [31:0] bytes_hi_first(input logic [31:0] four);
    bytes_hi_first = {four[7:0], four[15:8], four[23:16], four[31:24]};
  endfunction
endpackage

// File: rtl/rxmb_rst_sync.sv
module rxmb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/rxmb_timer.sv
module rxmb_timer #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] tcnt
);
  logic [TS_W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tcnt = cnt_q;
endmodule

// File: rtl/rxmb_filter.sv
module rxmb_filter import rxmb_pkg::*; #(
  parameter int NUM_MBOX = 8
) (
  input  logic [31:0]                fword,
  input  logic [NUM_MBOX-1:0][31:0]  mb_id,
  input  logic [NUM_MBOX-1:0][31:0]  mb_mask,
  input  logic [NUM_MBOX-1:0]        pend,
  input  logic [NUM_MBOX-1:0]        prot,
  output logic [NUM_MBOX-1:0]        take
);
  for (genvar i = 0; i < NUM_MBOX; i++) begin : g_mb
    logic [31:0] dc;
    logic        hit;
    always_comb begin
      dc   = mb_id[i][30] ? mb_mask[i] : 32'd0;
      hit  = (((fword ^ mb_id[i]) & ID_CARE & ~dc) == 32'd0);
      take[i] = hit & (~pend[i] | ~prot[i]);
    end
  end
endmodule

// File: rtl/rxmb_pick.sv
module rxmb_pick #(
  parameter int N = 8
) (
  input  logic         en,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) gnt = N'(1) << i;
    end
    if (!en) gnt = '0;
  end
endmodule

// File: rtl/rx_mbox_bank.sv
module rx_mbox_bank import rxmb_pkg::*; #(
  parameter int NUM_MBOX = 8,
  parameter int TS_W     = 32,
  parameter int ADDR_W   = 4 + $clog2(NUM_MBOX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frm_valid,
  input  logic [28:0]         frm_id,
  input  logic                frm_ext,
  input  logic                frm_rtr,
  input  logic [3:0]          frm_len,
  input  logic [63:0]         frm_data,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic [NUM_MBOX-1:0] rx_pend,
  output logic                rx_drop_irq
);
  localparam int MB_W = ADDR_W - 4;

  logic rst_s;
  logic [TS_W-1:0] tcnt;

  logic [NUM_MBOX-1:0][31:0]     id_q, mask_q, dlo_q, dhi_q;
  logic [NUM_MBOX-1:0][4:0]      ctl_q;
  logic [NUM_MBOX-1:0][TS_W-1:0] ts_q;
  logic [NUM_MBOX-1:0]           pend_q, pend_d, lost_q, lost_d, prot_q, prot_d;
  logic                          drop_q, drop_d;

  logic [NUM_MBOX-1:0] take, st_vec;
  logic [31:0]         fword, dlo_in, dhi_in;

  logic            is_glb;
  logic [MB_W-1:0] mb_sel;
  logic [2:0]      wd;
  logic            glb_wr;

  rxmb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_s));

  rxmb_timer #(.TS_W(TS_W)) u_tmr (.clk(clk), .rst_n(rst_s), .tcnt(tcnt));

  always_comb begin
    fword  = id_word(frm_id, frm_ext);
    dlo_in = bytes_hi_first(frm_data[31:0]);
    dhi_in = bytes_hi_first(frm_data[63:32]);
  end

  rxmb_filter #(.NUM_MBOX(NUM_MBOX)) u_flt (
    .fword(fword), .mb_id(id_q), .mb_mask(mask_q),
    .pend(pend_q), .prot(prot_q), .take(take)
  );

  rxmb_pick #(.N(NUM_MBOX)) u_pick (.en(frm_valid), .req(take), .gnt(st_vec));

  // address decode
  always_comb begin
    is_glb = reg_addr[ADDR_W-1];
    mb_sel = reg_addr[ADDR_W-2:3];
    wd     = reg_addr[2:0];
    glb_wr = reg_wr & is_glb;
  end

  // flag next state
  always_comb begin
    pend_d = pend_q;
    lost_d = lost_q;
    prot_d = prot_q;
    drop_d = drop_q;
    if (glb_wr && wd == GW_PEND) pend_d = pend_d & ~reg_wdata[NUM_MBOX-1:0];
    if (glb_wr && wd == GW_LOST) lost_d = lost_d & ~reg_wdata[NUM_MBOX-1:0];
    if (glb_wr && wd == GW_PROT) prot_d = reg_wdata[NUM_MBOX-1:0];
    if (glb_wr && wd == GW_STAT && reg_wdata[0]) drop_d = 1'b0;
    pend_d = pend_d | st_vec;
    lost_d = lost_d | (st_vec & pend_q);
    if (frm_valid && st_vec == '0) drop_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pend_q <= '0;
      lost_q <= '0;
      prot_q <= '0;
      drop_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      lost_q <= lost_d;
      prot_q <= prot_d;
      drop_q <= drop_d;
    end
  end

  // per-mailbox storage
  for (genvar i = 0; i < NUM_MBOX; i++) begin : g_mb
    logic        wr_id, wr_mask, id_en;
    logic [31:0] id_d;

    always_comb begin
      wr_id   = reg_wr & ~is_glb & (int'(mb_sel) == i) & (wd == WD_ID);
      wr_mask = reg_wr & ~is_glb & (int'(mb_sel) == i) & (wd == WD_MASK);
      id_en   = wr_id | st_vec[i];
      id_d    = st_vec[i] ? {fword[31], id_q[i][30], fword[29:0]} : reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_s) begin
      if (!rst_s) begin
        id_q[i]   <= '0;
        mask_q[i] <= '0;
      end else begin
        if (id_en)   id_q[i]   <= id_d;
        if (wr_mask) mask_q[i] <= reg_wdata;
      end
    end

    // payload: no reset, loaded only on store
    always_ff @(posedge clk) begin
      if (st_vec[i]) begin
        ctl_q[i] <= {frm_rtr, frm_len};
        dlo_q[i] <= dlo_in;
        dhi_q[i] <= dhi_in;
        ts_q[i]  <= tcnt;
      end
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (is_glb) begin
      case (wd)
        GW_PEND: reg_rdata[NUM_MBOX-1:0] = pend_q;
        GW_LOST: reg_rdata[NUM_MBOX-1:0] = lost_q;
        GW_PROT: reg_rdata[NUM_MBOX-1:0] = prot_q;
        GW_STAT: reg_rdata[0]            = drop_q;
        GW_TIME: reg_rdata[TS_W-1:0]     = tcnt;
        default: reg_rdata = '0;
      endcase
    end else if (int'(mb_sel) < NUM_MBOX) begin
      case (wd)
        WD_ID:    reg_rdata            = id_q[mb_sel];
        WD_CTL:   reg_rdata[4:0]       = ctl_q[mb_sel];
        WD_DLO:   reg_rdata            = dlo_q[mb_sel];
        WD_DHI:   reg_rdata            = dhi_q[mb_sel];
        WD_STAMP: reg_rdata[TS_W-1:0]  = ts_q[mb_sel];
        WD_MASK:  reg_rdata            = mask_q[mb_sel];
        default:  reg_rdata = '0;
      endcase
    end
  end

  assign rx_pend     = pend_q;
  assign rx_drop_irq = drop_q;
endmodule

// File: rtl/rxmb_chk.sv
module rxmb_chk #(
  parameter int NUM_MBOX = 8,
  parameter int TS_W     = 32
) (
  input logic                clk,
  input logic                rst_s,
  input logic                frm_valid,
  input logic                reg_wr,
  input logic [NUM_MBOX-1:0] st_vec,
  input logic [NUM_MBOX-1:0] pend_q,
  input logic [NUM_MBOX-1:0] lost_q,
  input logic [NUM_MBOX-1:0] prot_q,
  input logic                drop_q,
  input logic [TS_W-1:0]     tcnt
);
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(st_vec)); // R2

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_s)
    (st_vec != '0) |=> ((pend_q & $past(st_vec)) == $past(st_vec))); // R1

  AST_PROTECT_SKIP: assert property (@(posedge clk) disable iff (!rst_s)
    ((st_vec & pend_q & prot_q) == '0)); // R3

  AST_LOST_SET: assert property (@(posedge clk) disable iff (!rst_s)
    ((st_vec & pend_q) != '0) |=> ((lost_q & $past(st_vec & pend_q)) == $past(st_vec & pend_q))); // R4

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |=> (tcnt == $past(tcnt) + 1'b1)); // R7

  AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_s)
    (frm_valid && st_vec == '0) |=> drop_q); // R9

  AST_DROP_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_s)
    (frm_valid && st_vec == '0 && !reg_wr) |=> ($stable(pend_q) && $stable(lost_q))); // R9
endmodule

bind rx_mbox_bank rxmb_chk #(.NUM_MBOX(NUM_MBOX), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_s(rst_s), .frm_valid(frm_valid), .reg_wr(reg_wr),
  .st_vec(st_vec), .pend_q(pend_q), .lost_q(lost_q), .prot_q(prot_q),
  .drop_q(drop_q), .tcnt(tcnt)
);

// File: tb/tb_rx_mbox_bank.sv
module tb_rx_mbox_bank;
  localparam int N  = 4;
  localparam int AW = 4 + $clog2(N);

  logic          clk, rst_n;
  logic          frm_valid, frm_ext, frm_rtr;
  logic [28:0]   frm_id;
  logic [3:0]    frm_len;
  logic [63:0]   frm_data;
  logic          reg_wr;
  logic [AW-1:0] reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic [N-1:0]  rx_pend;
  logic          rx_drop_irq;

  int n_chk = 0;
  int n_bad = 0;

  rx_mbox_bank #(.NUM_MBOX(N), .TS_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_id(frm_id),
    .frm_ext(frm_ext), .frm_rtr(frm_rtr), .frm_len(frm_len), .frm_data(frm_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_pend(rx_pend), .rx_drop_irq(rx_drop_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [28:0] id;
    logic        ext;
    logic        rtr;
    logic [3:0]  len;
    logic [1:0]  mb;
    logic [3:0]  pend;
    logic [3:0]  lost;
  } vec_t;

  // mb3: exact std 0x123, protected; mb2/mb1 accept all, protected; mb0 accept all, open
  localparam vec_t VEC [5] = '{
    '{29'h123,     1'b0, 1'b0, 4'd8, 2'd3, 4'b1000, 4'b0000},
    '{29'h123,     1'b0, 1'b0, 4'd3, 2'd2, 4'b1100, 4'b0000},
    '{29'h1ABCDEF, 1'b1, 1'b1, 4'd0, 2'd1, 4'b1110, 4'b0000},
    '{29'h055,     1'b0, 1'b0, 4'd5, 2'd0, 4'b1111, 4'b0000},
    '{29'h077,     1'b1, 1'b0, 4'd2, 2'd0, 4'b1111, 4'b0001}
  };

  function automatic logic [AW-1:0] mba(input int mb, input logic [2:0] w);
    return {1'b0, 2'(mb), w};
  endfunction
  function automatic logic [AW-1:0] gla(input logic [2:0] w);
    return {1'b1, 2'b00, w};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send(input logic [28:0] id, input logic ext, input logic rtr,
                      input logic [3:0] len, output logic [31:0] ts);
    @(negedge clk);
    frm_id = id; frm_ext = ext; frm_rtr = rtr; frm_len = len;
    frm_data = 64'h8877_6655_4433_2211;
    frm_valid = 1'b1;
    rd(gla(3'd4), ts);
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, ts, expid;
    rst_n = 1'b0; frm_valid = 1'b0; frm_id = '0; frm_ext = 1'b0; frm_rtr = 1'b0;
    frm_len = '0; frm_data = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    rd(gla(3'd0), d); chk("R11 pend", d, 0);
    rd(gla(3'd1), d); chk("R11 lost", d, 0);
    rd(gla(3'd2), d); chk("R11 prot", d, 0);
    rd(gla(3'd3), d); chk("R11 stat", d, 0);
    rd(mba(0, 3'd0), d); chk("R11 id", d, 0);
    rd(mba(2, 3'd5), d); chk("R11 mask", d, 0);

    // configuration through the R10 address map
    wr(mba(3, 3'd0), 32'h123 << 18);
    for (int m = 0; m < 3; m++) begin
      wr(mba(m, 3'd0), 32'h4000_0000);
      wr(mba(m, 3'd5), 32'hFFFF_FFFF);
    end
    wr(gla(3'd2), 32'h0000_000E);

    // table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < 5; v++) begin
      send(VEC[v].id, VEC[v].ext, VEC[v].rtr, VEC[v].len, ts);
      expid = {VEC[v].ext, (VEC[v].mb != 2'd3), 2'b00, 28'd0} |
              (VEC[v].ext ? {3'b000, VEC[v].id} : ({21'd0, VEC[v].id[10:0]} << 18));
      rd(mba(VEC[v].mb, 3'd0), d); chk("R2/R3/R5 id of target", d, expid);
      rd(mba(VEC[v].mb, 3'd1), d); chk("R5 ctl", d, {27'd0, VEC[v].rtr, VEC[v].len});
      rd(gla(3'd0), d); chk("R1/R3 pend", d, {28'd0, VEC[v].pend});
      rd(gla(3'd1), d); chk("R4 lost", d, {28'd0, VEC[v].lost});
      if (v == 0) begin
        rd(mba(3, 3'd2), d); chk("R8 data lo", d, 32'h1122_3344);
        rd(mba(3, 3'd3), d); chk("R8 data hi", d, 32'h5566_7788);
        rd(mba(3, 3'd4), d); chk("R7 stamp", d, ts);
      end
    end

    // R4 lost clear
    wr(gla(3'd1), 32'h1);
    rd(gla(3'd1), d); chk("R4 lost w1c", d, 0);

    // R9 drop with every mailbox pending and protected
    wr(gla(3'd2), 32'hF);
    send(29'h200, 1'b0, 1'b0, 4'd1, ts);
    rd(gla(3'd3), d); chk("R9 status", d, 1);
    chk("R9 irq pin", {31'd0, rx_drop_irq}, 1);
    rd(gla(3'd0), d); chk("R9 pend kept", d, 32'hF);
    rd(mba(0, 3'd0), d); chk("R9 mb0 id kept", d, 32'hC000_0077);
    rd(gla(3'd1), d); chk("R9 lost kept", d, 0);
    wr(gla(3'd3), 32'h1);
    rd(gla(3'd3), d); chk("R9 status w1c", d, 0);

    // R1 pending clear
    wr(gla(3'd0), 32'hF);
    rd(gla(3'd0), d); chk("R1 pend w1c", d, 0);
    chk("R1 pend pin", {28'd0, rx_pend}, 0);

    // R6 masked match on mb3
    wr(mba(3, 3'd0), 32'h448C_0000);
    wr(mba(3, 3'd5), 32'h003C_0000);
    send(29'h12A, 1'b0, 1'b0, 4'd1, ts);
    rd(gla(3'd0), d); chk("R6 masked hit", d, 32'h8);
    rd(mba(3, 3'd0), d); chk("R5/R6 id keeps enable", d, 32'h44A8_0000);
    wr(gla(3'd0), 32'h8);
    send(29'h133, 1'b0, 1'b0, 4'd1, ts);
    rd(gla(3'd0), d); chk("R6 unmasked bit miss, R2 next", d, 32'h4);

    // R7 counter advances
    rd(gla(3'd4), ts);
    @(negedge clk);
    rd(gla(3'd4), d); chk("R7 time step", d, ts + 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule